// File: doc/BRIEF.md
# Indirect Entry Table Controller

This block holds two internal tables that software reaches only through a staging window and a command register, never by direct address. There are 32 scheme entries of 31 words each and 64 port entries. A port entry holds two words: a scheme-binding vector and a classification-plan word. The block sits on a simple 32-bit register bus. Software places data in the staging window, then writes the command register with the start bit set. The block moves one selected entry between the window and the table. The start bit reads back as a busy flag until the transfer is done.

The command register selects the direction, the entry kind, the entry index and, for port entries, which of the two words take part. After busy clears, the error bit reports a command that named no valid entry. Such a command changes neither storage nor window. The block does not decode the binding vector: by convention, scheme n is bound to a port by bit (31-n) of that port's binding word. A global configuration register keeps a single enable bit.

Top module: `cls_tbl_ctrl`

## Requirements
- R1: After reset, the configuration register, the command register (busy and error included), all 31 window words and every scheme and port entry read as zero.
- R2: The register map is as follows. 0x000 is the configuration register; only bit 31 is kept and the other bits read 0. Window word i (0..30) is at 0x100+4i. The command register is at 0x1FC. Every other address reads 0. Read data and rvalid_o appear in the cycle after a read request.
- R3: Command bit 31 is start/busy. A write to 0x1FC with bit 31 set starts a transfer, and bit 31 then reads 1 for exactly 4 cycles. A write to 0x1FC with bit 31 clear has no effect. Only bits 30, 25:24, 20:16, 15:14 and 7:0 are stored and read back.
- R4: While busy, writes to the command register and to the window are ignored.
- R5: Scheme write (bits 25:24 = 00, bit 30 = 0, index in bits 20:16) copies window words to the entry. Window word 16 is the packet counter and is copied only when bit 15 = 1; the other 30 words are always copied.
- R6: Scheme read (bit 30 = 1) copies all 31 entry words, counter included, into the window.
- R7: Port entry (bits 25:24 = 10, port in bits 7:0). Bit 15 selects the binding word, exchanged with window word 0. Bit 14 selects the plan word, exchanged with window word 1. Bit 30 gives the direction, and unselected words are left untouched.
- R8: Bits 25:24 = 01 exchange the plan word of the port in bits 7:0 with window word 1, regardless of bits 15:14.
- R9: A port number of 64 or more, a scheme index beyond the table, or kind 11 sets bit 29 once busy clears and leaves storage and window unchanged. The next accepted start clears bit 29.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus request, one access per cycle |
| we_i | input | 1 | 1 write, 0 read |
| addr_i | input | 9 | Byte address, word aligned |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |

## Verification
The assertions take for granted that req_i, we_i and addr_i carry known values at every clock edge, and that a read request is answered in the next cycle whatever the block is doing. They also assume no bus access depends on the state of a transfer, except through the busy gating the block applies itself. The stimulus drives all inputs on the falling edge, uses only word-aligned addresses, and issues at most one access per cycle. The stimulus also deliberately issues command and window writes while a transfer is in flight, so that the busy gating is exercised.

// File: rtl/cls_tbl_pkg.sv
package cls_tbl_pkg;
  localparam int unsigned ADDR_W = 9;
  localparam logic [ADDR_W-1:0] CFG_OFS = 9'h000;
  localparam logic [ADDR_W-1:0] ACT_OFS = 9'h1FC;

  localparam int unsigned GO_BIT  = 31;
  localparam int unsigned DIR_BIT = 30;
  localparam int unsigned ERR_BIT = 29;
  localparam int unsigned SELA_BIT = 15;
  localparam int unsigned SELB_BIT = 14;
  localparam logic [31:0] ACT_MASK = 32'h431F_C0FF;

  typedef enum logic [1:0] {
    ENT_SCHEME = 2'b00,
    ENT_PLAN   = 2'b01,
    ENT_PORT   = 2'b10,
    ENT_BAD    = 2'b11
  } ent_e;
endpackage

// File: rtl/cls_cmd_decode.sv
module cls_cmd_decode
  import cls_tbl_pkg::*;
#(
  parameter int unsigned NUM_SCHEMES = 32,
  parameter int unsigned NUM_PORTS   = 64,
  localparam int unsigned SIDX_W = $clog2(NUM_SCHEMES),
  localparam int unsigned PIDX_W = $clog2(NUM_PORTS)
) (
  input  logic [31:0]       act_i,
  output logic              rd_o,
  output logic              err_o,
  output logic              sch_o,
  output logic              port_o,
  output logic              sp_sel_o,
  output logic              cpp_sel_o,
  output logic              cnt_sel_o,
  output logic [SIDX_W-1:0] sidx_o,
  output logic [PIDX_W-1:0] pidx_o
);
  ent_e       ent;
  logic [4:0] sch_raw;
  logic [7:0] port_raw;
  logic       sch_oor, port_oor;

  assign ent      = ent_e'(act_i[25:24]);
  assign sch_raw  = act_i[20:16];
  assign port_raw = act_i[7:0];
  assign sch_oor  = int'(sch_raw) >= int'(NUM_SCHEMES);
  assign port_oor = int'(port_raw) >= int'(NUM_PORTS);
  assign rd_o     = act_i[DIR_BIT];
  assign cnt_sel_o = act_i[SELA_BIT];
  assign sidx_o   = sch_raw[SIDX_W-1:0];
  assign pidx_o   = port_raw[PIDX_W-1:0];

  always_comb begin
    err_o     = 1'b0;
    sch_o     = 1'b0;
    port_o    = 1'b0;
    sp_sel_o  = 1'b0;
    cpp_sel_o = 1'b0;
    unique case (ent)
      ENT_SCHEME: begin
        err_o = sch_oor;
        sch_o = ~sch_oor;
      end
      ENT_PLAN: begin
        err_o     = port_oor;
        port_o    = ~port_oor;
        cpp_sel_o = 1'b1;
      end
      ENT_PORT: begin
        err_o     = port_oor;
        port_o    = ~port_oor;
        sp_sel_o  = act_i[SELA_BIT];
        cpp_sel_o = act_i[SELB_BIT];
      end
      default: err_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/cls_xfer_seq.sv
module cls_xfer_seq #(
  parameter int unsigned XFER_CYCLES = 4,
  localparam int unsigned CW = $clog2(XFER_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  logic [CW-1:0] cnt_q;
  logic          busy_q;

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == CW'(XFER_CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (done_o) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/cls_scheme_mem.sv
module cls_scheme_mem #(
  parameter int unsigned NUM_SCHEMES = 32,
  parameter int unsigned WORDS       = 31,
  parameter int unsigned CNT_WORD    = 16,
  localparam int unsigned SIDX_W = $clog2(NUM_SCHEMES)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic                        cnt_we_i,
  input  logic [SIDX_W-1:0]           idx_i,
  input  logic [WORDS-1:0][31:0]      wdata_i,
  output logic [WORDS-1:0][31:0]      rdata_o
);
  logic [NUM_SCHEMES-1:0][WORDS-1:0][31:0] mem_q;

  assign rdata_o = mem_q[idx_i];

  // counter word is written only on explicit request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
    end else if (we_i) begin
      for (int w = 0; w < int'(WORDS); w++) begin
        if (w != int'(CNT_WORD) || cnt_we_i) mem_q[idx_i][w] <= wdata_i[w];
      end
    end
  end
endmodule

// File: rtl/cls_port_mem.sv
module cls_port_mem #(
  parameter int unsigned NUM_PORTS = 64,
  localparam int unsigned PIDX_W = $clog2(NUM_PORTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sp_we_i,
  input  logic              cpp_we_i,
  input  logic [PIDX_W-1:0] idx_i,
  input  logic [31:0]       sp_wdata_i,
  input  logic [31:0]       cpp_wdata_i,
  output logic [31:0]       sp_rdata_o,
  output logic [31:0]       cpp_rdata_o
);
  logic [NUM_PORTS-1:0][31:0] sp_q;
  logic [NUM_PORTS-1:0][31:0] cpp_q;

  assign sp_rdata_o  = sp_q[idx_i];
  assign cpp_rdata_o = cpp_q[idx_i];

  for (genvar p = 0; p < int'(NUM_PORTS); p++) begin : g_port
    logic hit;
    assign hit = (idx_i == PIDX_W'(p));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sp_q[p]  <= '0;
        cpp_q[p] <= '0;
      end else begin
        if (sp_we_i && hit)  sp_q[p]  <= sp_wdata_i;
        if (cpp_we_i && hit) cpp_q[p] <= cpp_wdata_i;
      end
    end
  end
endmodule

// File: rtl/cls_tbl_ctrl.sv
module cls_tbl_ctrl
  import cls_tbl_pkg::*;
#(
  parameter int unsigned NUM_SCHEMES = 32,
  parameter int unsigned NUM_PORTS   = 64,
  parameter int unsigned SCH_WORDS   = 31,
  parameter int unsigned CNT_WORD    = 16,
  parameter int unsigned XFER_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              rvalid_o
);
  localparam int unsigned SIDX_W  = $clog2(NUM_SCHEMES);
  localparam int unsigned PIDX_W  = $clog2(NUM_PORTS);
  localparam int unsigned WSEL_W  = $clog2(SCH_WORDS);

  logic                      cfg_en_q;
  logic [31:0]               act_q;
  logic                      err_q;
  logic [SCH_WORDS-1:0][31:0] win_q;
  logic [31:0]               rdata_q;
  logic                      rvalid_q;

  logic xfer_busy, xfer_done, launch;
  logic dec_rd, dec_err, dec_sch, dec_port, dec_sp, dec_cpp, dec_cnt;
  logic [SIDX_W-1:0] dec_sidx;
  logic [PIDX_W-1:0] dec_pidx;
  logic [SCH_WORDS-1:0][31:0] sch_rdata;
  logic [31:0] sp_rdata, cpp_rdata;
  logic commit;

  logic [5:0]        aw;
  logic              win_hit;
  logic [WSEL_W-1:0] win_sel;
  logic [31:0]       rd_mux;

  assign aw      = addr_i[7:2];
  assign win_hit = addr_i[8] && (addr_i[1:0] == 2'b00) && (int'(aw) < int'(SCH_WORDS));
  assign win_sel = aw[WSEL_W-1:0];
  assign launch  = req_i && we_i && !xfer_busy && (addr_i == ACT_OFS) && wdata_i[GO_BIT];
  assign commit  = xfer_done && !dec_err;

  cls_xfer_seq #(.XFER_CYCLES(XFER_CYCLES)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (launch),
    .busy_o  (xfer_busy),
    .done_o  (xfer_done)
  );

  cls_cmd_decode #(.NUM_SCHEMES(NUM_SCHEMES), .NUM_PORTS(NUM_PORTS)) u_dec (
    .act_i     (act_q),
    .rd_o      (dec_rd),
    .err_o     (dec_err),
    .sch_o     (dec_sch),
    .port_o    (dec_port),
    .sp_sel_o  (dec_sp),
    .cpp_sel_o (dec_cpp),
    .cnt_sel_o (dec_cnt),
    .sidx_o    (dec_sidx),
    .pidx_o    (dec_pidx)
  );

  cls_scheme_mem #(.NUM_SCHEMES(NUM_SCHEMES), .WORDS(SCH_WORDS), .CNT_WORD(CNT_WORD)) u_sch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (commit && dec_sch && !dec_rd),
    .cnt_we_i (dec_cnt),
    .idx_i    (dec_sidx),
    .wdata_i  (win_q),
    .rdata_o  (sch_rdata)
  );

  cls_port_mem #(.NUM_PORTS(NUM_PORTS)) u_port (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sp_we_i     (commit && dec_port && dec_sp && !dec_rd),
    .cpp_we_i    (commit && dec_port && dec_cpp && !dec_rd),
    .idx_i       (dec_pidx),
    .sp_wdata_i  (win_q[0]),
    .cpp_wdata_i (win_q[1]),
    .sp_rdata_o  (sp_rdata),
    .cpp_rdata_o (cpp_rdata)
  );

  // command, error, config and window state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_en_q <= 1'b0;
      act_q    <= '0;
      err_q    <= 1'b0;
      win_q    <= '0;
    end else begin
      if (req_i && we_i && addr_i == CFG_OFS) cfg_en_q <= wdata_i[31];
      if (launch) begin
        act_q <= wdata_i & ACT_MASK;
        err_q <= 1'b0;
      end
      if (req_i && we_i && !xfer_busy && win_hit) win_q[win_sel] <= wdata_i;
      if (xfer_done) err_q <= dec_err;
      if (commit && dec_rd) begin
        if (dec_sch) win_q <= sch_rdata;
        if (dec_port && dec_sp)  win_q[0] <= sp_rdata;
        if (dec_port && dec_cpp) win_q[1] <= cpp_rdata;
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr_i == CFG_OFS)      rd_mux = {cfg_en_q, 31'b0};
    else if (addr_i == ACT_OFS) rd_mux = act_q | {xfer_busy, 1'b0, err_q, 29'b0};
    else if (win_hit)           rd_mux = win_q[win_sel];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= req_i && !we_i;
      if (req_i && !we_i) rdata_q <= rd_mux;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
endmodule

// File: rtl/cls_tbl_ctrl_chk.sv
module cls_tbl_ctrl_chk
  import cls_tbl_pkg::*;
#(
  parameter int unsigned XFER_CYCLES = 4,
  parameter int unsigned SCH_WORDS   = 31
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    req_i,
  input logic                    we_i,
  input logic [ADDR_W-1:0]       addr_i,
  input logic                    rvalid_o,
  input logic                    busy_i,
  input logic                    done_i,
  input logic                    err_i,
  input logic [31:0]             act_i,
  input logic [SCH_WORDS*32-1:0] win_i
);
  logic [31:0] run_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_cnt <= '0;
    else if (busy_i) run_cnt <= run_cnt + 32'd1;
    else             run_cnt <= '0;
  end

  // R3
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> (run_cnt == 32'(XFER_CYCLES)));

  // R3
  start_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(req_i && we_i && addr_i == ACT_OFS));

  // R4
  cmd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(act_i));

  // R4
  win_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !done_i) |=> $stable(win_i));

  // R9
  err_at_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_i) |-> $fell(busy_i));

  // R2
  rvalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);
endmodule

bind cls_tbl_ctrl cls_tbl_ctrl_chk #(.XFER_CYCLES(XFER_CYCLES), .SCH_WORDS(SCH_WORDS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .rvalid_o (rvalid_o),
  .busy_i   (xfer_busy),
  .done_i   (xfer_done),
  .err_i    (err_q),
  .act_i    (act_q),
  .win_i    (win_q)
);

// File: tb/sim_cls_tbl_ctrl.sv
`timescale 1ns/1ps
module sim_cls_tbl_ctrl;
  localparam logic [8:0]  ACT  = 9'h1FC;
  localparam logic [31:0] MASK = 32'h431F_C0FF;
  localparam logic [31:0] GO   = 32'h8000_0000;
  localparam logic [31:0] RDB  = 32'h4000_0000;
  localparam logic [31:0] ERRB = 32'h2000_0000;
  localparam int CNTW = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [8:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic rvalid;

  always #4 clk = ~clk;

  cls_tbl_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid)
  );

  int checks = 0, errors = 0;
  logic [31:0] m_win [31];
  logic [31:0] m_sch [32][31];
  logic [31:0] m_sp  [64];
  logic [31:0] m_cpp [64];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [8:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [8:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    d = rdata;
    req = 1'b0;
  endtask

  task automatic win_wr(input int w, input logic [31:0] d);
    bus_wr(9'(9'h100 + 4 * w), d);
    m_win[w] = d;
  endtask

  function automatic logic exp_err(input logic [31:0] c);
    if (c[25:24] == 2'b11) return 1'b1;
    if (c[25:24] == 2'b00) return int'(c[20:16]) >= 32;
    return int'(c[7:0]) >= 64;
  endfunction

  task automatic model_apply(input logic [31:0] c);
    int s, p;
    logic rd;
    s = int'(c[20:16]); p = int'(c[7:0]); rd = c[30];
    if (exp_err(c)) return;
    case (c[25:24])
      2'b00: for (int w = 0; w < 31; w++) begin
        if (rd) m_win[w] = m_sch[s][w];
        else if (w != CNTW || c[15]) m_sch[s][w] = m_win[w];
      end
      2'b01: if (rd) m_win[1] = m_cpp[p]; else m_cpp[p] = m_win[1];
      default: begin
        if (c[15]) begin if (rd) m_win[0] = m_sp[p];  else m_sp[p]  = m_win[0]; end
        if (c[14]) begin if (rd) m_win[1] = m_cpp[p]; else m_cpp[p] = m_win[1]; end
      end
    endcase
  endtask

  task automatic wait_idle(output logic [31:0] d);
    d = GO;
    for (int i = 0; i < 20 && d[31]; i++) bus_rd(ACT, d);
  endtask

  task automatic check_window(input string tag);
    logic [31:0] d;
    for (int w = 0; w < 31; w++) begin
      bus_rd(9'(9'h100 + 4 * w), d);
      chk(tag, d, m_win[w]);
    end
  endtask

  task automatic run_cmd(input logic [31:0] c, input string tag);
    logic [31:0] d;
    logic e;
    e = exp_err(c);
    bus_wr(ACT, c);
    model_apply(c);
    wait_idle(d);
    chk(e ? "R9" : tag, d, (c & MASK) | (e ? ERRB : 32'h0));
    check_window(e ? "R9" : tag);
  endtask

  function automatic string tag_of(input logic [31:0] c);
    if (c[25:24] == 2'b00) return c[30] ? "R6" : "R5";
    if (c[25:24] == 2'b01) return "R8";
    return "R7";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d, c;
    void'($urandom(32'h5EED_0042));
    foreach (m_win[i]) m_win[i] = '0;
    foreach (m_sp[i]) begin m_sp[i] = '0; m_cpp[i] = '0; end
    for (int s = 0; s < 32; s++) for (int w = 0; w < 31; w++) m_sch[s][w] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_rd(9'h000, d); chk("R1", d, 32'h0);
    bus_rd(ACT, d);    chk("R1", d, 32'h0);
    check_window("R1");
    run_cmd(GO | RDB | (32'd31 << 16), "R1");
    run_cmd(GO | RDB | 32'h0200_C000 | 32'd63, "R1");

    // R2 map and read timing
    bus_wr(9'h000, 32'hFFFF_FFFF);
    bus_rd(9'h000, d); chk("R2", d, 32'h8000_0000);
    chk("R2", {31'b0, rvalid}, 32'h1);
    @(negedge clk);
    chk("R2", {31'b0, rvalid}, 32'h0);
    bus_wr(9'h004, 32'h1234_5678);
    bus_rd(9'h004, d); chk("R2", d, 32'h0);
    win_wr(30, 32'hA5A5_0030);
    bus_rd(9'h17C, d); chk("R2", d, 32'h0);
    bus_rd(9'h178, d); chk("R2", d, 32'hA5A5_0030);

    // R3 busy length
    c = GO | RDB | (32'd4 << 16);
    bus_wr(ACT, c);
    model_apply(c);
    for (int i = 0; i < 5; i++) begin
      bus_rd(ACT, d);
      chk("R3", {31'b0, d[31]}, (i < 4) ? 32'h1 : 32'h0);
    end
    check_window("R6");
    // R3 write without start ignored
    bus_wr(ACT, RDB | 32'h0200_00FF);
    bus_rd(ACT, d); chk("R3", d, c & MASK);

    // R4 writes during busy ignored
    win_wr(5, 32'hCAFE_0005);
    c = GO | (32'd7 << 16);
    bus_wr(ACT, c);
    model_apply(c);
    bus_wr(9'h114, 32'hDEAD_0005);
    bus_wr(ACT, GO | RDB | (32'd2 << 16));
    wait_idle(d);
    chk("R4", d, c & MASK);
    bus_rd(9'h114, d); chk("R4", d, 32'hCAFE_0005);
    run_cmd(GO | RDB | (32'd7 << 16), "R4");

    // R5 counter word gated by bit 15
    for (int w = 0; w < 31; w++) win_wr(w, 32'h1100_0000 + 32'(w));
    run_cmd(GO | (32'd9 << 16), "R5");
    run_cmd(GO | RDB | (32'd9 << 16), "R5");
    chk("R5", m_win[CNTW], 32'h0);
    for (int w = 0; w < 31; w++) win_wr(w, 32'h2200_0000 + 32'(w));
    run_cmd(GO | 32'h0000_8000 | (32'd9 << 16), "R5");
    run_cmd(GO | RDB | (32'd9 << 16), "R6");
    chk("R5", m_win[CNTW], 32'h2200_0010);

    // R7 port words, R8 plan kind, R9 errors
    win_wr(0, 32'h8000_0001); win_wr(1, 32'h0000_00C3);
    run_cmd(GO | 32'h0200_C000 | 32'd12, "R7");
    win_wr(0, 32'h0); win_wr(1, 32'h0);
    run_cmd(GO | RDB | 32'h0200_4000 | 32'd12, "R7");
    run_cmd(GO | RDB | 32'h0100_0000 | 32'd12, "R8");
    win_wr(0, 32'h7777_7777);
    run_cmd(GO | 32'h0200_8000 | 32'd64, "R9");
    run_cmd(GO | RDB | 32'h0200_8000 | 32'd12, "R7");
    run_cmd(GO | RDB | 32'h0300_0000, "R9");
    run_cmd(GO | RDB | 32'h0200_8000 | 32'd12, "R9");

    // constrained random mix
    for (int n = 0; n < 250; n++) begin
      int r, k;
      logic [31:0] junk;
      k = int'($urandom % 4);
      for (int i = 0; i < k; i++) win_wr(int'($urandom % 31), $urandom);
      r = int'($urandom % 10);
      c = GO | ($urandom & RDB) | ($urandom & 32'h0000_C000) | (32'($urandom % 32) << 16);
      if (r < 4)      c |= 32'h0000_0000;
      else if (r < 6) c |= 32'h0100_0000;
      else if (r < 9) c |= 32'h0200_0000;
      else            c |= 32'h0300_0000;
      c |= ($urandom % 8 == 0) ? 32'(64 + $urandom % 192) : 32'($urandom % 64);
      junk = $urandom & ~MASK & ~GO & ~ERRB;
      run_cmd(c | junk, tag_of(c));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule